// File: doc/BRIEF.md
# Serial Register-Access Frame Engine

This block is a serial slave that gives a host access to a bank of sixteen registers, each up to twelve bits wide, over a clock and two data lines with no chip select. A transfer is a fixed frame of 24 bits. A two-bit start pattern opens the frame, and a bit counter closes it. An idle timer puts the counter back to the start if the host stops in the middle of a frame. The engine decodes an address and a command from the frame. It returns the addressed register on its output line and hands writes and clears to an external register file through a simple one-cycle strobe port.

The serial clock and data are oversampled by the block's system clock. Incoming bits are taken on the rising serial edge, and the output line changes on the falling edge. Each frame ends in a four-bit check code. The code on the input stream gates every change the frame would make. A separate code is computed over the output stream and sent on it, so the host can verify what it read. A control address lets the host switch input checking off and on. The same address can also release the output line for a while, so that other slaves can share the wires. The line is taken back after a quiet period counted from a 1 MHz tick.

Top module: `sfe_frame_engine`

## Requirements
- R1: After reset, `sout_oe` is 1, `sout` is 0, no strobe or event output is active, and input check-code verification is enabled.
- R2: A frame is 24 bits, taken MSB first on rising `sclk`, in this order: start pattern 0 then 1, a 4-bit address, a 2-bit command, data bits 7 down to 0, data bits 11 down to 8, and 4 check bits. The commands are 00 read, 01 clear, 10 release output and 11 write.
- R3: After the falling `sclk` edge that follows the rising edge of frame bit i, `sout` shows output-stream bit i. For bits 0 to 7 this is a copy of the input bit i.
- R4: Output-stream bits 8 to 19 carry the addressed register's content, sampled when bit 7 is received, in the same order as the input data. Bits 11 to 8 are sent as zeros when `reg_wide` is 0.
- R5: The check code is the remainder of the first 20 stream bits modulo x^4+1, starting from zero, which equals the XOR of the five 4-bit groups. Output bits 20 to 23 carry this code computed over output bits 0 to 19.
- R6: A write (11) to any address other than 15, with a valid start and a matching check code, gives one `reg_we` pulse after bit 23, with `reg_addr` equal to the address and `reg_wdata` equal to the 12 data bits.
- R7: While checking is enabled, a frame with a valid start and a mismatched check code makes no write, clear or release, and pulses `evt_crc_err` once.
- R8: A frame whose first two bits are not 0 then 1 pulses `evt_start_err` and makes no write, clear or release.
- R9: A clear (01) gives a `reg_clr` pulse only at address 6. At any other address it acts as a plain read.
- R10: A write to address 15 with a matching check code toggles checking and writes no register. While checking is off, frames with a mismatched code are committed and no `evt_crc_err` is raised.
- R11: A release (10) at address 15 drops `sout_oe` after the frame's last output bit. At other addresses it acts as a plain read. While released, serial edges are not decoded.
- R12: While released, after 1500 ticks with no `sclk` edge, `sout_oe` returns to 1 with a one-cycle `evt_restore` pulse. Every `sclk` edge restarts this count.
- R13: When a frame has started and 1500 ticks pass with no `sclk` edge, the bit counter returns to the start, and the next bit is decoded as frame bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse every microsecond |
| sclk | input | 1 | Serial clock from host, idle low |
| sin | input | 1 | Serial data from host |
| sout | output | 1 | Serial data to host |
| sout_oe | output | 1 | Output enable for `sout` |
| reg_addr | output | 4 | Address of the register being accessed |
| reg_rdata | input | 12 | Content of the register at `reg_addr` |
| reg_wide | input | 1 | Register at `reg_addr` is 12 bits wide |
| reg_we | output | 1 | One-cycle write strobe |
| reg_clr | output | 1 | One-cycle clear strobe |
| reg_wdata | output | 12 | Data for the write strobe |
| evt_start_err | output | 1 | Pulse on a bad start pattern |
| evt_crc_err | output | 1 | Pulse on an input check-code mismatch |
| evt_restore | output | 1 | Pulse when the output is taken back |

## Verification
The assertions rely on three properties of the inputs. `sclk` holds each level for at least three system clocks, `sin` is stable from before a rising `sclk` edge until after its synchronised copy is taken, and `reg_rdata` follows `reg_addr` within one clock. The stimulus meets all three by holding every `sclk` level and every data bit for four clock cycles. It also answers reads from a combinational register model, and it applies the timeouts only through deliberate idle gaps of known length.

// File: rtl/sfe_pkg.sv
// Shared command encoding and frame constants for the serial frame engine.
package sfe_pkg;
    typedef enum logic [1:0] {
        CMD_READ  = 2'b00,
        CMD_CLEAR = 2'b01,
        CMD_REL   = 2'b10,
        CMD_WRITE = 2'b11
    } cmd_e;

    localparam logic [1:0] START_PAT = 2'b01;
endpackage

// File: rtl/sfe_edge_sync.sv
// Brings the serial clock and data into the system clock domain and
// flags rising and falling serial edges for one cycle each.
// Assumes sclk holds each level for at least three clk cycles.
module sfe_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sin,
    output logic rise,
    output logic fall,
    output logic sin_s
);
    logic [2:0] sck_q;
    logic [1:0] sin_q;

    // Two-stage synchroniser plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= '0;
            sin_q <= '0;
        end else begin
            sck_q <= {sck_q[1:0], sclk};
            sin_q <= {sin_q[0], sin};
        end
    end

    assign rise  = sck_q[1] & ~sck_q[2];
    assign fall  = ~sck_q[1] & sck_q[2];
    assign sin_s = sin_q[1];
endmodule

// File: rtl/sfe_crc_serial.sv
// Bit-serial remainder generator, MSB first, for polynomial POLY of degree W.
// clr together with en starts a new remainder with the current bit.
module sfe_crc_serial #(
    parameter int           W    = 4,
    parameter logic [W:0]   POLY = 5'h11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic         bit_in,
    output logic [W-1:0] crc
);
    logic [W-1:0] base;
    logic         fb;

    // Next-remainder feedback from the (optionally cleared) current value.
    always_comb begin
        base = clr ? '0 : crc;
        fb   = base[W-1] ^ bit_in;
    end

    // Advance the remainder by one bit when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)  crc <= '0;
        else if (en) crc <= {base[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
    end

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> $stable(crc)); // R5
endmodule

// File: rtl/sfe_idle_timer.sv
// Counts tick pulses while run is high; any restart or a low run clears it.
// Pulses expired for one cycle when LIMIT ticks pass without a restart.
module sfe_idle_timer #(
    parameter int LIMIT = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Tick counter with restart and one-shot expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (restart || !run) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == LAST) begin
                    cnt     <= '0;
                    expired <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R12
endmodule

// File: rtl/sfe_frame_engine.sv
// Serial register-access frame engine. Decodes 24-bit frames delimited by a
// start pattern and a bit count, echoes the header, returns register data
// with a check code, and commits writes/clears only on a valid check code.
// Assumes reg_rdata/reg_wide follow reg_addr combinationally.
module sfe_frame_engine
    import sfe_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int DATA_W        = 12,
    parameter int CRC_W         = 4,
    parameter int TIMEOUT_TICKS = 1500,
    parameter int CLR_ADDR      = 6,
    parameter int CTL_ADDR      = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sclk,
    input  logic              sin,
    output logic              sout,
    output logic              sout_oe,
    output logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_wide,
    output logic              reg_we,
    output logic              reg_clr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              evt_start_err,
    output logic              evt_crc_err,
    output logic              evt_restore
);
    localparam int HDR_W = 2 + ADDR_W + 2;
    localparam int LO_W  = 8;
    localparam int HI_W  = DATA_W - LO_W;
    localparam int PAY   = HDR_W + DATA_W;
    localparam int FRAME = PAY + CRC_W;
    localparam int CNT_W = $clog2(FRAME);
    localparam logic [CNT_W-1:0] I_START = CNT_W'(1);
    localparam logic [CNT_W-1:0] I_ADDR  = CNT_W'(HDR_W - 3);
    localparam logic [CNT_W-1:0] I_CMD   = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] I_HDR   = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] I_PAY   = CNT_W'(PAY);
    localparam logic [CNT_W-1:0] I_LAST  = CNT_W'(FRAME - 1);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_ADDR);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_ADDR);

    logic sck_rise, sck_fall, sin_s, expired;
    logic rise_act, fall_act, run_timer;
    logic [CNT_W-1:0]  bit_cnt, out_idx;
    logic              out_pend, last_bit, stream_bit;
    logic [HDR_W-1:0]  hdr_sh;
    cmd_e              cmd_q;
    logic              start_ok, crc_chk_en, rel_arm, rel_q, crc_match;
    logic [DATA_W-1:0] dseq, dsh;
    logic [CRC_W-2:0]  rxc;
    logic [CRC_W-1:0]  in_crc, out_crc, ocrc_sh;

    sfe_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sin),
        .rise(sck_rise), .fall(sck_fall), .sin_s(sin_s)
    );

    assign rise_act  = sck_rise && !rel_q;
    assign fall_act  = sck_fall && !rel_q && out_pend;
    assign run_timer = rel_q || (bit_cnt != '0) || out_pend;

    sfe_idle_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run_timer),
        .restart(sck_rise | sck_fall), .tick(tick), .expired(expired)
    );

    sfe_crc_serial #(.W(CRC_W), .POLY(5'h11)) u_crc_in (
        .clk(clk), .rst_n(rst_n), .en(rise_act && (bit_cnt < I_PAY)),
        .clr(bit_cnt == '0), .bit_in(sin_s), .crc(in_crc)
    );

    sfe_crc_serial #(.W(CRC_W), .POLY(5'h11)) u_crc_out (
        .clk(clk), .rst_n(rst_n), .en(fall_act && (out_idx < I_PAY)),
        .clr(out_idx == '0), .bit_in(stream_bit), .crc(out_crc)
    );

    // Selects the output-stream bit for the slot just sampled.
    always_comb begin
        if (out_idx < I_HDR)       stream_bit = last_bit;
        else if (out_idx < I_PAY)  stream_bit = dseq[DATA_W-1];
        else if (out_idx == I_PAY) stream_bit = out_crc[CRC_W-1];
        else                       stream_bit = ocrc_sh[CRC_W-1];
    end

    assign crc_match = ({rxc, sin_s} == in_crc);

    // Frame sequencer: bit counting, decode, commit, release and timeouts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;  out_idx <= '0;  out_pend <= 1'b0;  last_bit <= 1'b0;
            hdr_sh <= '0;   cmd_q <= CMD_READ;  start_ok <= 1'b0;
            crc_chk_en <= 1'b1;  rel_arm <= 1'b0;  rel_q <= 1'b0;
            dseq <= '0;  dsh <= '0;  rxc <= '0;  ocrc_sh <= '0;
            sout <= 1'b0;  sout_oe <= 1'b1;  reg_addr <= '0;  reg_wdata <= '0;
            reg_we <= 1'b0;  reg_clr <= 1'b0;
            evt_start_err <= 1'b0;  evt_crc_err <= 1'b0;  evt_restore <= 1'b0;
        end else begin
            reg_we <= 1'b0;  reg_clr <= 1'b0;
            evt_start_err <= 1'b0;  evt_crc_err <= 1'b0;  evt_restore <= 1'b0;
            if (expired) begin
                if (rel_q) begin
                    rel_q       <= 1'b0;
                    sout_oe     <= 1'b1;
                    evt_restore <= 1'b1;
                end else begin
                    bit_cnt  <= '0;
                    out_pend <= 1'b0;
                    rel_arm  <= 1'b0;
                end
            end else if (rise_act) begin
                hdr_sh   <= {hdr_sh[HDR_W-2:0], sin_s};
                last_bit <= sin_s;
                out_idx  <= bit_cnt;
                out_pend <= 1'b1;
                bit_cnt  <= (bit_cnt == I_LAST) ? '0 : bit_cnt + 1'b1;
                if (bit_cnt == I_START) begin
                    start_ok <= ({hdr_sh[0], sin_s} == START_PAT);
                    if ({hdr_sh[0], sin_s} != START_PAT) evt_start_err <= 1'b1;
                end
                if (bit_cnt == I_ADDR) reg_addr <= {hdr_sh[ADDR_W-2:0], sin_s};
                if (bit_cnt == I_CMD) begin
                    cmd_q <= cmd_e'({hdr_sh[0], sin_s});
                    dseq  <= {reg_rdata[LO_W-1:0],
                              reg_wide ? reg_rdata[DATA_W-1:LO_W] : {HI_W{1'b0}}};
                end
                if (bit_cnt >= I_HDR && bit_cnt < I_PAY) dsh <= {dsh[DATA_W-2:0], sin_s};
                if (bit_cnt >= I_PAY && bit_cnt < I_LAST) rxc <= {rxc[CRC_W-3:0], sin_s};
                if (bit_cnt == I_LAST) begin
                    if (start_ok && crc_chk_en && !crc_match) evt_crc_err <= 1'b1;
                    case (cmd_q)
                        CMD_WRITE: begin
                            if (reg_addr == A_CTL) begin
                                if (start_ok && crc_match) crc_chk_en <= ~crc_chk_en;
                            end else if (start_ok && (crc_match || !crc_chk_en)) begin
                                reg_we    <= 1'b1;
                                reg_wdata <= {dsh[HI_W-1:0], dsh[DATA_W-1:HI_W]};
                            end
                        end
                        CMD_CLEAR:
                            if (reg_addr == A_CLR && start_ok && (crc_match || !crc_chk_en))
                                reg_clr <= 1'b1;
                        CMD_REL:
                            if (reg_addr == A_CTL && start_ok && (crc_match || !crc_chk_en))
                                rel_arm <= 1'b1;
                        default: ;
                    endcase
                end
            end else if (fall_act) begin
                out_pend <= 1'b0;
                sout     <= stream_bit;
                if (out_idx >= I_HDR && out_idx < I_PAY) dseq <= {dseq[DATA_W-2:0], 1'b0};
                if (out_idx == I_PAY) ocrc_sh <= {out_crc[CRC_W-2:0], 1'b0};
                else if (out_idx > I_PAY) ocrc_sh <= {ocrc_sh[CRC_W-2:0], 1'b0};
                if (out_idx == I_LAST && rel_arm) begin
                    rel_arm <= 1'b0;
                    rel_q   <= 1'b1;
                    sout_oe <= 1'b0;
                end
            end
        end
    end

    AST_WE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(bit_cnt) == I_LAST); // R6
    AST_NO_COMMIT_ON_CRC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_crc_err |-> !reg_we && !reg_clr); // R7
    AST_CLEAR_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clr |-> reg_addr == A_CLR); // R9
    AST_QUIET_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !sout_oe |-> !reg_we && !reg_clr); // R11
    AST_RESTORE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sout_oe) |-> evt_restore); // R12
endmodule

// File: tb/sfe_frame_engine_test.sv
// Directed bench: one task per scenario, each checking its own results.
module sfe_frame_engine_test;
    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sclk = 1'b0, sin = 1'b0;
    logic sout, sout_oe, reg_we, reg_clr, evt_start_err, evt_crc_err, evt_restore;
    logic [3:0]  reg_addr;
    logic [11:0] reg_rdata, reg_wdata;
    logic        reg_wide;
    logic [11:0] regs [16];
    int checks = 0, fails = 0;
    int n_we = 0, n_clr = 0, n_crc = 0, n_start = 0, n_rest = 0;
    logic [3:0]  last_wa;
    logic [11:0] last_wd;
    logic        tdiv = 1'b0;

    always #10 clk = ~clk;

    sfe_frame_engine uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sclk(sclk), .sin(sin),
        .sout(sout), .sout_oe(sout_oe), .reg_addr(reg_addr),
        .reg_rdata(reg_rdata), .reg_wide(reg_wide), .reg_we(reg_we),
        .reg_clr(reg_clr), .reg_wdata(reg_wdata), .evt_start_err(evt_start_err),
        .evt_crc_err(evt_crc_err), .evt_restore(evt_restore)
    );

    // Register-file model and event monitor.
    assign reg_rdata = regs[reg_addr];
    assign reg_wide  = reg_addr[3];
    always @(posedge clk) begin
        tdiv <= ~tdiv;
        tick <= tdiv;
        if (rst_n) begin
            if (reg_we) begin
                n_we <= n_we + 1; last_wa <= reg_addr; last_wd <= reg_wdata;
                regs[reg_addr] <= reg_wdata;
            end
            if (reg_clr) begin n_clr <= n_clr + 1; regs[reg_addr] <= 12'h000; end
            if (evt_crc_err)   n_crc   <= n_crc + 1;
            if (evt_start_err) n_start <= n_start + 1;
            if (evt_restore)   n_rest  <= n_rest + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] nx(input logic [19:0] p);
        return p[19:16] ^ p[15:12] ^ p[11:8] ^ p[7:4] ^ p[3:0];
    endfunction

    function automatic logic [23:0] mk(input logic [3:0] a, input logic [1:0] c,
                                       input logic [11:0] d);
        logic [19:0] p;
        p = {2'b01, a, c, d[7:0], d[11:8]};
        return {p, nx(p)};
    endfunction

    function automatic logic [23:0] exp_out(input logic [23:0] f, input logic [11:0] rd,
                                            input bit wide);
        logic [19:0] p;
        p = {f[23:16], rd[7:0], wide ? rd[11:8] : 4'h0};
        return {p, nx(p)};
    endfunction

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clocks out the first n bits of f, MSB first, and collects sout.
    task automatic xfer(input logic [23:0] f, input int n, output logic [23:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            sin = f[23-i];
            clk_n(4); sclk = 1'b1;
            clk_n(4); sclk = 1'b0;
            clk_n(4); got[23-i] = sout;
        end
    endtask

    task automatic t_reset;
        chk(sout_oe === 1'b1, "R1 oe", 32'(sout_oe), 1);
        chk(sout === 1'b0, "R1 sout", 32'(sout), 0);
        chk(n_we + n_clr + n_crc + n_start + n_rest == 0, "R1 events",
            n_we + n_clr + n_crc + n_start + n_rest, 0);
    endtask

    task automatic t_read(input logic [3:0] a, input logic [1:0] c, input string tag);
        logic [23:0] f, g, e;
        f = mk(a, c, 12'h000);
        e = exp_out(f, regs[a], a[3]);
        xfer(f, 24, g);
        chk(g === e, tag, 32'(g), 32'(e));
    endtask

    task automatic t_write;
        logic [23:0] g;
        int w0;
        w0 = n_we;
        xfer(mk(4'd2, 2'b11, 12'h5A3), 24, g);
        chk(n_we == w0 + 1, "R6 strobe", n_we, w0 + 1);
        chk(last_wa == 4'd2 && last_wd == 12'h5A3, "R6 data", {last_wa, last_wd}, {4'd2, 12'h5A3});
        t_read(4'd2, 2'b00, "R4 narrow readback after write");
    endtask

    task automatic t_bad_crc;
        logic [23:0] g;
        int w0, c0;
        w0 = n_we; c0 = n_crc;
        xfer(mk(4'd2, 2'b11, 12'h111) ^ 24'h1, 24, g);
        chk(n_we == w0, "R7 no write", n_we, w0);
        chk(n_crc == c0 + 1, "R7 crc event", n_crc, c0 + 1);
    endtask

    task automatic t_bad_start;
        logic [23:0] f, g;
        int w0, s0;
        w0 = n_we; s0 = n_start;
        f = mk(4'd2, 2'b11, 12'h222);
        f[23:22] = 2'b10;
        xfer(f, 24, g);
        chk(n_start == s0 + 1, "R8 start event", n_start, s0 + 1);
        chk(n_we == w0, "R8 no write", n_we, w0);
    endtask

    task automatic t_clear;
        int c0;
        c0 = n_clr;
        t_read(4'd6, 2'b01, "R9 read before clear");
        chk(n_clr == c0 + 1 && regs[6] == 12'h0, "R9 clear at 6", n_clr, c0 + 1);
        t_read(4'd5, 2'b01, "R9 clear elsewhere reads");
        chk(n_clr == c0 + 1, "R9 no clear at 5", n_clr, c0 + 1);
    endtask

    task automatic t_crc_toggle;
        logic [23:0] g;
        int w0, c0;
        w0 = n_we; c0 = n_crc;
        xfer(mk(4'd15, 2'b11, 12'hABC), 24, g);
        chk(n_we == w0, "R10 ctl no write", n_we, w0);
        xfer(mk(4'd4, 2'b11, 12'h0F0) ^ 24'h1, 24, g);
        chk(n_we == w0 + 1 && last_wd == 12'h0F0, "R10 unchecked commit", n_we, w0 + 1);
        chk(n_crc == c0, "R10 no crc event", n_crc, c0);
        xfer(mk(4'd15, 2'b11, 12'h000), 24, g);
        xfer(mk(4'd4, 2'b11, 12'h0AA) ^ 24'h1, 24, g);
        chk(n_we == w0 + 1 && n_crc == c0 + 1, "R10 checking back on", n_we, w0 + 1);
    endtask

    task automatic t_release;
        logic [23:0] g;
        int w0;
        t_read(4'd14, 2'b10, "R11 release elsewhere reads");
        chk(sout_oe === 1'b1, "R11 oe kept", 32'(sout_oe), 1);
        xfer(mk(4'd15, 2'b10, 12'h000), 24, g);
        chk(sout_oe === 1'b0, "R11 released", 32'(sout_oe), 0);
        w0 = n_we;
        xfer(mk(4'd2, 2'b11, 12'h777), 24, g);
        chk(n_we == w0 && sout_oe === 1'b0, "R11 foreign ignored", n_we, w0);
        clk_n(2800);
        chk(sout_oe === 1'b0 && n_rest == 0, "R12 still released", 32'(sout_oe), 0);
        clk_n(400);
        chk(sout_oe === 1'b1 && n_rest == 1, "R12 restored", {31'(n_rest), sout_oe}, {31'd1, 1'b1});
    endtask

    task automatic t_frame_timeout;
        logic [23:0] g;
        int s0;
        s0 = n_start;
        xfer(mk(4'd3, 2'b11, 12'hFFF), 10, g);
        clk_n(3200);
        t_read(4'd9, 2'b00, "R13 resync after idle");
        chk(n_start == s0, "R13 no start event", n_start, s0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 12'(i * 12'h1A7) ^ 12'h5C3;
        clk_n(5);
        rst_n = 1'b1;
        clk_n(3);
        t_reset();
        t_read(4'd3, 2'b00, "R3 R4 R5 narrow read");
        t_read(4'd9, 2'b00, "R2 R4 R5 wide read");
        t_write();
        t_bad_crc();
        t_bad_start();
        t_clear();
        t_crc_toggle();
        t_release();
        t_frame_timeout();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule